// File: doc/BRIEF.md
# Operand Hazard Resolver for a Five-Stage Pipeline

This block is the combinational hazard logic of a five-stage load/store pipeline with 32 architectural registers. It looks at the two source register fields of the instruction sitting in decode. It compares them with the destination registers of the older instructions now in the execute and memory stages. From those comparisons it decides whether decode can proceed with operands taken from the register file, must take a bypassed value, or must wait.

The handling policy is chosen at run time through a two-bit mode input. With handling off, the block stays silent and the pipeline runs unprotected. In stall-only mode, every detected dependency freezes fetch and decode and sends a bubble into execute. In bypass mode, results are steered from the execute or memory stage into the decode operands. A stall is raised only when the execute-stage producer is a load, because its data does not exist yet.

A producer is considered only when it writes a register other than register 0. The first source field is always compared. The second source field is compared only when the producing instruction is register-register or a store. The datapath multiplexers, the ALU, the register file and branch resolution all live outside this block.

Top module: `hz_unit`

## Requirements
- R1: The mode input is decoded as 2'b00 = handling off, 2'b01 = stall-only, 2'b10 = bypass. The code 2'b11 behaves as handling off. With handling off, stall, hold_fetch, hold_decode and bubble_ex are 0 and both select outputs are 2'b00, whatever the stage inputs are.
- R2: A producer (execute or memory stage) takes part only when its write-enable is 1 and its destination is not 0. A producer with write-enable 0 or destination 0 never causes a stall or a bypass.
- R3: A producer is in conflict with decode when its destination equals dec_rs. It is also in conflict when its destination equals dec_rt and that producer is flagged register-register (rtype) or store. A destination that equals only dec_rt of an immediate-class, non-store producer is no conflict.
- R4: In stall-only mode, a conflict with either producer sets stall, and both select outputs stay 2'b00.
- R5: In bypass mode, a conflict with an execute-stage producer whose load flag is 1 sets stall. While stall is 1, both select outputs are 2'b00.
- R6: In bypass mode, when the execute-stage producer is in conflict and is not a load, fwd_rs becomes 2'b01 if ex_dst equals dec_rs, and fwd_rt becomes 2'b01 if ex_dst equals dec_rt. Both may be set together, and there is no stall.
- R7: In bypass mode, a memory-stage producer in conflict sets fwd_rs to 2'b10 when mem_dst equals dec_rs, and fwd_rt to 2'b10 when mem_dst equals dec_rt. It never stalls.
- R8: When both producers would bypass into the same operand, the execute-stage code 2'b01 wins over the memory-stage code 2'b10. The two operands are resolved independently.
- R9: hold_fetch, hold_decode and bubble_ex are each equal to stall at all times.
- R10: The select code 2'b11 never appears on fwd_rs or fwd_rt. 2'b00 means the register file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | Handling policy: 00 off, 01 stall-only, 10 bypass, 11 off |
| dec_rs | input | 5 | First source register of the decode-stage instruction |
| dec_rt | input | 5 | Second source register of the decode-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | 5 | Execute-stage destination register |
| ex_load | input | 1 | Execute-stage instruction reads memory |
| ex_rtype | input | 1 | Execute-stage instruction is register-register class |
| ex_store | input | 1 | Execute-stage instruction is a store |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_rtype | input | 1 | Memory-stage instruction is register-register class |
| mem_store | input | 1 | Memory-stage instruction is a store |
| stall | output | 1 | Decode must wait this cycle |
| hold_fetch | output | 1 | Keep the fetch stage contents |
| hold_decode | output | 1 | Keep the decode stage contents |
| bubble_ex | output | 1 | Load a no-op into execute |
| fwd_rs | output | 2 | Source select for the first operand: 00 register file, 01 execute, 10 memory |
| fwd_rt | output | 2 | Source select for the second operand, same code |

## Verification
The assertions assume that all inputs are at known levels and are settled when evaluated. They make no assumption about how the class flags combine, so a producer may be flagged load and store together. The stimulus applies one complete input set per cycle and holds it until the comparison in the opposite clock phase. Register numbers are drawn mostly from the range 0 to 3, so that equal fields, register 0 and double matches turn up often across all four mode codes.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    HZ_OFF   = 2'b00,
    HZ_STALL = 2'b01,
    HZ_FWD   = 2'b10,
    HZ_RSVD  = 2'b11
  } hz_mode_e;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_EX  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;

  localparam int unsigned NPROD  = 2;
  localparam int unsigned P_EX   = 0;
  localparam int unsigned P_MEM  = 1;
  localparam int unsigned NOPND  = 2;
  localparam int unsigned O_RS   = 0;
  localparam int unsigned O_RT   = 1;

  // only the two defined policies do anything; the spare code is treated as off
  function automatic logic is_stall_only(input logic [1:0] m);
    return m == HZ_STALL;
  endfunction

  function automatic logic is_bypass(input logic [1:0] m);
    return m == HZ_FWD;
  endfunction

  // second-field comparison applies only to register-register or store producers
  function automatic logic rt_checked(input logic rtype, input logic store);
    return rtype | store;
  endfunction

  // younger stage wins
  function automatic logic [1:0] pick_src(input logic ex_ok, input logic mem_ok);
    if (ex_ok)       return SRC_EX;
    else if (mem_ok) return SRC_MEM;
    else             return SRC_RF;
  endfunction

endpackage

// File: rtl/hz_producer_match.sv
module hz_producer_match #(
  parameter int unsigned AW = 5
) (
  input  logic          wen,
  input  logic [AW-1:0] dst,
  input  logic          rtype,
  input  logic          store,
  input  logic [AW-1:0] src_rs,
  input  logic [AW-1:0] src_rt,
  output logic          conflict,
  output logic          to_rs,
  output logic          to_rt
);
  import hz_pkg::*;

  logic live;
  logic eq_rs;
  logic eq_rt;
  logic hit_rs;
  logic hit_rt;

  always_comb begin
    live     = wen && (dst != '0);
    eq_rs    = (dst == src_rs);
    eq_rt    = (dst == src_rt);
    hit_rs   = live && eq_rs;
    hit_rt   = live && eq_rt && rt_checked(rtype, store);
    conflict = hit_rs || hit_rt;
    // once a conflict exists the value goes to every field it names
    to_rs    = conflict && eq_rs;
    to_rt    = conflict && eq_rt;
  end

endmodule

// File: rtl/hz_policy.sv
module hz_policy (
  input  logic [1:0] mode,
  input  logic       ex_conflict,
  input  logic       ex_load,
  input  logic       mem_conflict,
  output logic       stall,
  output logic       bypass_en
);
  import hz_pkg::*;

  logic any_conflict;
  logic load_use;

  always_comb begin
    any_conflict = ex_conflict || mem_conflict;
    load_use     = ex_conflict && ex_load;
    stall        = 1'b0;
    bypass_en    = 1'b0;
    if (is_stall_only(mode)) begin
      stall = any_conflict;
    end else if (is_bypass(mode)) begin
      stall     = load_use;
      bypass_en = !load_use;
    end
  end

endmodule

// File: rtl/hz_src_select.sv
module hz_src_select (
  input  logic       bypass_en,
  input  logic       ex_ok,
  input  logic       mem_ok,
  output logic [1:0] sel
);
  import hz_pkg::*;

  always_comb begin
    sel = SRC_RF;
    if (bypass_en) sel = pick_src(ex_ok, mem_ok);
  end

endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
  parameter int unsigned AW = 5
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          ex_wen,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_load,
  input  logic          ex_rtype,
  input  logic          ex_store,
  input  logic          mem_wen,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_rtype,
  input  logic          mem_store,
  output logic          stall,
  output logic          hold_fetch,
  output logic          hold_decode,
  output logic          bubble_ex,
  output logic [1:0]    fwd_rs,
  output logic [1:0]    fwd_rt
);
  import hz_pkg::*;

  logic [NPROD-1:0]         p_wen;
  logic [NPROD-1:0][AW-1:0] p_dst;
  logic [NPROD-1:0]         p_rtype;
  logic [NPROD-1:0]         p_store;
  logic [NPROD-1:0]         p_conflict;
  logic [NPROD-1:0]         p_to_rs;
  logic [NPROD-1:0]         p_to_rt;

  assign p_wen[P_EX]    = ex_wen;
  assign p_dst[P_EX]    = ex_dst;
  assign p_rtype[P_EX]  = ex_rtype;
  assign p_store[P_EX]  = ex_store;
  assign p_wen[P_MEM]   = mem_wen;
  assign p_dst[P_MEM]   = mem_dst;
  assign p_rtype[P_MEM] = mem_rtype;
  assign p_store[P_MEM] = mem_store;

  generate
    for (genvar g = 0; g < NPROD; g++) begin : g_prod
      hz_producer_match #(.AW(AW)) u_match (
        .wen      (p_wen[g]),
        .dst      (p_dst[g]),
        .rtype    (p_rtype[g]),
        .store    (p_store[g]),
        .src_rs   (dec_rs),
        .src_rt   (dec_rt),
        .conflict (p_conflict[g]),
        .to_rs    (p_to_rs[g]),
        .to_rt    (p_to_rt[g])
      );
    end
  endgenerate

  logic stall_int;
  logic bypass_en;

  hz_policy u_policy (
    .mode         (mode),
    .ex_conflict  (p_conflict[P_EX]),
    .ex_load      (ex_load),
    .mem_conflict (p_conflict[P_MEM]),
    .stall        (stall_int),
    .bypass_en    (bypass_en)
  );

  logic [NOPND-1:0]      o_ex_ok;
  logic [NOPND-1:0]      o_mem_ok;
  logic [NOPND-1:0][1:0] o_sel;

  assign o_ex_ok[O_RS]  = p_to_rs[P_EX];
  assign o_mem_ok[O_RS] = p_to_rs[P_MEM];
  assign o_ex_ok[O_RT]  = p_to_rt[P_EX];
  assign o_mem_ok[O_RT] = p_to_rt[P_MEM];

  generate
    for (genvar k = 0; k < NOPND; k++) begin : g_opnd
      hz_src_select u_sel (
        .bypass_en (bypass_en),
        .ex_ok     (o_ex_ok[k]),
        .mem_ok    (o_mem_ok[k]),
        .sel       (o_sel[k])
      );
    end
  endgenerate

  assign stall       = stall_int;
  assign hold_fetch  = stall_int;
  assign hold_decode = stall_int;
  assign bubble_ex   = stall_int;
  assign fwd_rs      = o_sel[O_RS];
  assign fwd_rt      = o_sel[O_RT];

endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [1:0]    mode,
  input logic [AW-1:0] dec_rs,
  input logic [AW-1:0] dec_rt,
  input logic          ex_wen,
  input logic [AW-1:0] ex_dst,
  input logic          ex_load,
  input logic          mem_wen,
  input logic [AW-1:0] mem_dst,
  input logic          stall,
  input logic          hold_fetch,
  input logic          hold_decode,
  input logic          bubble_ex,
  input logic [1:0]    fwd_rs,
  input logic [1:0]    fwd_rt
);

  logic ex_dead;
  logic mem_dead;
  assign ex_dead  = !ex_wen || (ex_dst == '0);
  assign mem_dead = !mem_wen || (mem_dst == '0);

  always_comb begin
    // R1
    off_quiet_chk: assert (!(mode == 2'b00 || mode == 2'b11) ||
                           (!stall && fwd_rs == 2'b00 && fwd_rt == 2'b00));
    // R2
    dead_producer_chk: assert (!(ex_dead && mem_dead) ||
                               (!stall && fwd_rs == 2'b00 && fwd_rt == 2'b00));
    // R4
    stall_only_nofwd_chk: assert (mode != 2'b01 || (fwd_rs == 2'b00 && fwd_rt == 2'b00));
    // R5
    stall_excl_chk: assert (!stall || (fwd_rs == 2'b00 && fwd_rt == 2'b00));
    // R7
    mem_no_stall_chk: assert (!(mode == 2'b10 && (ex_dead || !ex_load)) || !stall);
    // R8
    ex_priority_chk: assert (!(mode == 2'b10 && !ex_load && !ex_dead && ex_dst == dec_rs) ||
                             fwd_rs == 2'b01);
    // R9
    hold_match_chk: assert (hold_fetch == stall && hold_decode == stall && bubble_ex == stall);
    // R10
    code_range_chk: assert (fwd_rs != 2'b11 && fwd_rt != 2'b11);
  end

endmodule

bind hz_unit hz_unit_chk #(.AW(AW)) u_chk (
  .mode        (mode),
  .dec_rs      (dec_rs),
  .dec_rt      (dec_rt),
  .ex_wen      (ex_wen),
  .ex_dst      (ex_dst),
  .ex_load     (ex_load),
  .mem_wen     (mem_wen),
  .mem_dst     (mem_dst),
  .stall       (stall),
  .hold_fetch  (hold_fetch),
  .hold_decode (hold_decode),
  .bubble_ex   (bubble_ex),
  .fwd_rs      (fwd_rs),
  .fwd_rt      (fwd_rt)
);

// File: tb/sim_hz_unit.sv
`timescale 1ns/1ps
module sim_hz_unit;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] mode = 2'b00;
  logic [4:0] dec_rs = '0, dec_rt = '0, ex_dst = '0, mem_dst = '0;
  logic ex_wen = 1'b0, ex_load = 1'b0, ex_rtype = 1'b0, ex_store = 1'b0;
  logic mem_wen = 1'b0, mem_rtype = 1'b0, mem_store = 1'b0;
  logic stall, hold_fetch, hold_decode, bubble_ex;
  logic [1:0] fwd_rs, fwd_rt;

  hz_unit u0 (
    .mode(mode), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_load(ex_load),
    .ex_rtype(ex_rtype), .ex_store(ex_store),
    .mem_wen(mem_wen), .mem_dst(mem_dst),
    .mem_rtype(mem_rtype), .mem_store(mem_store),
    .stall(stall), .hold_fetch(hold_fetch), .hold_decode(hold_decode),
    .bubble_ex(bubble_ex), .fwd_rs(fwd_rs), .fwd_rt(fwd_rt)
  );

  typedef struct {
    logic       st;
    logic [1:0] rs;
    logic [1:0] rt;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference: written from the requirement text
  function automatic exp_t model(
      input logic [1:0] m, input logic [4:0] rs, input logic [4:0] rt,
      input logic ew, input logic [4:0] ed, input logic el, input logic er, input logic es,
      input logic mw, input logic [4:0] md, input logic mr, input logic ms);
    exp_t e;
    bit ex_c, mem_c;
    e.st = 1'b0; e.rs = 2'b00; e.rt = 2'b00; e.tag = "R3";
    ex_c  = ew && ed != 0 && (ed == rs || ((er || es) && ed == rt));
    mem_c = mw && md != 0 && (md == rs || ((mr || ms) && md == rt));
    if (!(ex_c || mem_c)) e.tag = ((ew && ed == 0) || (mw && md == 0) || !ew || !mw) ? "R2" : "R3";
    if (m == 2'b01) begin
      e.st = ex_c || mem_c;
      if (e.st) e.tag = "R4";
    end else if (m == 2'b10) begin
      if (ex_c && el) begin
        e.st = 1'b1; e.tag = "R5";
      end else begin
        if (mem_c && md == rs) begin e.rs = 2'b10; e.tag = "R7"; end
        if (mem_c && md == rt) begin e.rt = 2'b10; e.tag = "R7"; end
        if (ex_c && ed == rs) begin
          e.rs = 2'b01;
          e.tag = (mem_c && md == rs) ? "R8" : "R6";
        end
        if (ex_c && ed == rt) begin
          e.rt = 2'b01;
          e.tag = (mem_c && md == rt) ? "R8" : "R6";
        end
      end
    end else begin
      e.tag = "R1";
    end
    return e;
  endfunction

  task automatic drive(
      input logic [1:0] m, input logic [4:0] rs, input logic [4:0] rt,
      input logic ew, input logic [4:0] ed, input logic el, input logic er, input logic es,
      input logic mw, input logic [4:0] md, input logic mr, input logic ms);
    @(posedge clk);
    #1;
    mode = m; dec_rs = rs; dec_rt = rt;
    ex_wen = ew; ex_dst = ed; ex_load = el; ex_rtype = er; ex_store = es;
    mem_wen = mw; mem_dst = md; mem_rtype = mr; mem_store = ms;
    sb.push_back(model(m, rs, rt, ew, ed, el, er, es, mw, md, mr, ms));
  endtask

  // monitor: compares in the falling phase
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (stall !== e.st || fwd_rs !== e.rs || fwd_rt !== e.rt) begin
        errors++;
        $display("FAIL %s: stall/rs/rt got %b/%b/%b expected %b/%b/%b",
                 e.tag, stall, fwd_rs, fwd_rt, e.st, e.rs, e.rt);
      end
      checks++;
      if (hold_fetch !== stall || hold_decode !== stall || bubble_ex !== stall) begin
        errors++;
        $display("FAIL R9: holds %b%b%b expected all %b", hold_fetch, hold_decode, bubble_ex, stall);
      end
      checks++;
      if (fwd_rs === 2'b11 || fwd_rt === 2'b11) begin
        errors++;
        $display("FAIL R10: selects %b/%b expected not 11", fwd_rs, fwd_rt);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // quiet start (R2)
    drive(2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1: off and spare code ignore a clear conflict
    drive(2'b00, 3, 4, 1, 3, 1, 1, 0, 1, 4, 1, 0);
    drive(2'b11, 3, 4, 1, 3, 0, 1, 0, 1, 4, 1, 0);
    // R2: write disabled, destination zero
    drive(2'b10, 3, 4, 0, 3, 0, 1, 0, 0, 4, 1, 0);
    drive(2'b01, 0, 0, 1, 0, 1, 1, 0, 1, 0, 1, 0);
    // R3: immediate-class producer on rt only -> nothing
    drive(2'b01, 5, 6, 1, 6, 0, 0, 0, 0, 0, 0, 0);
    drive(2'b10, 5, 6, 0, 0, 0, 0, 0, 1, 6, 0, 0);
    // R3/R4: store producer on rt counts
    drive(2'b01, 5, 6, 1, 6, 0, 0, 1, 0, 0, 0, 0);
    // R4: stall-only from each stage
    drive(2'b01, 7, 1, 1, 7, 0, 0, 0, 0, 0, 0, 0);
    drive(2'b01, 7, 1, 0, 0, 0, 0, 0, 1, 7, 0, 0);
    // R5: load in execute
    drive(2'b10, 9, 2, 1, 9, 1, 0, 0, 0, 0, 0, 0);
    drive(2'b10, 9, 2, 1, 9, 1, 0, 0, 1, 2, 1, 0);
    // R6: execute bypass, single and both fields
    drive(2'b10, 9, 2, 1, 9, 0, 0, 0, 0, 0, 0, 0);
    drive(2'b10, 8, 8, 1, 8, 0, 1, 0, 0, 0, 0, 0);
    drive(2'b10, 8, 8, 1, 8, 0, 0, 0, 0, 0, 0, 0);
    drive(2'b10, 1, 2, 1, 2, 0, 1, 0, 0, 0, 0, 0);
    // R7: memory bypass
    drive(2'b10, 4, 2, 0, 0, 0, 0, 0, 1, 4, 0, 0);
    drive(2'b10, 4, 2, 0, 0, 0, 0, 0, 1, 2, 1, 0);
    // R8: both producers on one field, and split fields
    drive(2'b10, 4, 2, 1, 4, 0, 0, 0, 1, 4, 0, 0);
    drive(2'b10, 4, 2, 1, 4, 0, 0, 0, 1, 2, 1, 0);
    drive(2'b10, 3, 3, 1, 3, 0, 1, 0, 1, 3, 1, 0);
    // mixed sweep on a small register range
    for (int i = 0; i < 400; i++) begin
      drive(2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
    end
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule